// File: doc/BRIEF.md
# Local Bus Burst Slave with Configurable Width

This block is the slave end of a synchronous processor local bus in front of a small internal word array. A transfer opens with an address phase. The address phase is accepted on a rising clock edge where strobe, select and a direction indication are all active. After that come one or more data beats. A beat completes only on an edge where three ready inputs agree. The transfer closes after the beat flagged as the last of the burst. Within a burst the internal address moves forward on each completed beat.

Two configuration inputs are latched at the address phase. The first is a 2-bit width field: code 01 gives a 16-bit bus carried on the upper half of the 32-bit data lines, and any other code, 11 in normal use, gives the full 32 bits. The second is a byte-enable style bit that picks active-low or active-high lane enables. The block exposes the array's address, write data and per-byte write strobes. It also drives the read data together with an output enable for the external tristate driver.

Top module: `lbus_slave`

## Requirements
- R1: An address phase is accepted only in the idle state, on an edge where `strobe_i`, `select_i` and at least one of `rd_i`/`wr_i` are high. Start conditions seen during a transfer, and ready beats seen while idle, have no effect.
- R2: The transfer is a write when `wr_i` is high at the address phase, even if `rd_i` is also high. Otherwise it is a read.
- R3: For a read, `data_oe_o` goes high from the edge after the address phase. It stays low through a whole write transfer.
- R4: A beat completes only when `rdy_in_n_i`=0, `rdy_in_i`=1 and `rdy_out_n_i`=0 on the same edge. On any other cycle `mem_we_o` is zero and the address does not move.
- R5: The transfer ends on the beat with `blast_i`=1, and `data_oe_o` is low in the following cycle.
- R6: Each completed beat advances the address by one 32-bit word in 32-bit mode. In 16-bit mode it advances by one halfword: the first beat uses the low halfword of the word, the second uses the high halfword, then the next word follows.
- R7: With `cfg_be_mode_i`=1, lane k (data bits 8k+7..8k) is enabled when `be_i[k]`=0. With `cfg_be_mode_i`=0, lane k is enabled when `be_i[k]`=1.
- R8: With `cfg_width_i`=01, only lanes 3 and 2 (`data_*[31:16]`) carry data and only `be_i[3:2]` count. Bus lane 3 maps to array byte 2h+1 and bus lane 2 maps to array byte 2h, where h is the halfword index. Read lanes 1 and 0 are driven as zero.
- R9: On a read beat, each enabled lane carries the stored byte and each disabled lane is driven as zero. On a write beat, only enabled bytes of the array change.
- R10: The starting array word is taken from the low `MEM_AW` bits of `addr_i`, which are word address lines. In 16-bit mode a burst starts on the low halfword.
- R11: After reset the block is idle, `data_oe_o` and `mem_we_o` are zero, and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width_i | input | 2 | Width code: 01 selects 16-bit, otherwise 32-bit |
| cfg_be_mode_i | input | 1 | Lane enable style: 1 active-low, 0 active-high |
| strobe_i | input | 1 | Transfer strobe |
| select_i | input | 1 | Slave select |
| rd_i | input | 1 | Read direction indication |
| wr_i | input | 1 | Write direction indication |
| addr_i | input | ADDR_W | Word address lines |
| be_i | input | 4 | Byte lane enables |
| blast_i | input | 1 | Last beat of the burst |
| rdy_in_n_i | input | 1 | Ready in, active low |
| rdy_in_i | input | 1 | Ready in, active high |
| rdy_out_n_i | input | 1 | Ready out, active low |
| data_i | input | 32 | Write data from the bus |
| data_o | output | 32 | Read data toward the bus |
| data_oe_o | output | 1 | Output enable for the read data driver |
| mem_addr_o | output | MEM_AW | Array word address in use |
| mem_wdata_o | output | 32 | Data presented to the array |
| mem_we_o | output | 4 | Per-byte array write strobes |

## Verification
The hardest case to reach is a beat where only two of the three ready lines agree. The stimulus must keep a burst open while one line is held off, then release it. The bench does this inside bursts: it places stall cycles where a single ready line is wrong and garbage sits on the data bus. It then confirms at the ports that no strobe fired, and checks that the later readback still shows the data of the real beats. A start pulse during an open read, and ready beats while idle, are brought out the same way through `data_oe_o` and `mem_we_o`.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } lbus_state_e;

    localparam logic [1:0] WIDTH_CODE_16 = 2'b01;
endpackage

// File: rtl/lbus_lane_decode.sv
module lbus_lane_decode #(
    parameter int NB = 4
) (
    input  logic [NB-1:0] be_i,
    input  logic          act_low_i,
    input  logic          half_mode_i,
    output logic [NB-1:0] lane_en_o
);
    localparam int HB = NB / 2;

    logic [NB-1:0] raw;

    always_comb begin
        raw = act_low_i ? ~be_i : be_i;
        if (half_mode_i) begin
            lane_en_o = {raw[NB-1:HB], {HB{1'b0}}};
        end else begin
            lane_en_o = raw;
        end
    end
endmodule

// File: rtl/lbus_regfile.sv
module lbus_regfile #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW/8-1:0] we_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o
);
    localparam int NB    = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int k = 0; k < NB; k++) begin
                if (we_i[k]) mem_q[addr_i][8*k +: 8] <= wdata_i[8*k +: 8];
            end
        end
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/lbus_slave.sv
module lbus_slave
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int MEM_AW = 6,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width_i,
    input  logic              cfg_be_mode_i,
    input  logic              strobe_i,
    input  logic              select_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW/8-1:0]   be_i,
    input  logic              blast_i,
    input  logic              rdy_in_n_i,
    input  logic              rdy_in_i,
    input  logic              rdy_out_n_i,
    input  logic [DW-1:0]     data_i,
    output logic [DW-1:0]     data_o,
    output logic              data_oe_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    output logic [DW/8-1:0]   mem_we_o
);
    localparam int NB = DW / 8;
    localparam int HB = NB / 2;
    localparam int HW = DW / 2;
    localparam int HA = MEM_AW + 1;   // halfword address width

    typedef struct packed {
        lbus_state_e   st;
        logic          wr;
        logic          half;
        logic          act_low;
        logic          oe;
        logic [HA-1:0] ha;
    } ctl_t;

    ctl_t q, d;

    logic          beat_ok, start_ok, xbeat, hsel;
    logic [NB-1:0] lane_en;
    logic [DW-1:0] rd_word, rd_raw, rdata;

    assign beat_ok  = ~rdy_in_n_i & rdy_in_i & ~rdy_out_n_i;
    assign start_ok = strobe_i & select_i & (rd_i | wr_i);
    assign xbeat    = (q.st == ST_XFER) & beat_ok;
    assign hsel     = q.ha[0];

    lbus_lane_decode #(.NB(NB)) lane_dec_i (
        .be_i       (be_i),
        .act_low_i  (q.act_low),
        .half_mode_i(q.half),
        .lane_en_o  (lane_en)
    );

    lbus_regfile #(.AW(MEM_AW), .DW(DW)) mem_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (mem_addr_o),
        .we_i   (mem_we_o),
        .wdata_i(mem_wdata_o),
        .rdata_o(rd_word)
    );

    // Lane steering between the bus and the array word.
    always_comb begin
        mem_addr_o = q.ha[HA-1:1];
        if (q.half) begin
            rd_raw      = {(hsel ? rd_word[DW-1:HW] : rd_word[HW-1:0]), {HW{1'b0}}};
            mem_wdata_o = {data_i[DW-1:HW], data_i[DW-1:HW]};
            mem_we_o    = hsel ? {lane_en[NB-1:HB], {HB{1'b0}}}
                               : {{HB{1'b0}}, lane_en[NB-1:HB]};
        end else begin
            rd_raw      = rd_word;
            mem_wdata_o = data_i;
            mem_we_o    = lane_en;
        end
        mem_we_o = mem_we_o & {NB{xbeat & q.wr}};
        for (int k = 0; k < NB; k++) begin
            rdata[8*k +: 8] = lane_en[k] ? rd_raw[8*k +: 8] : 8'h00;
        end
    end

    assign data_o    = rdata;
    assign data_oe_o = q.oe;

    // Next-state computation.
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                d.oe = 1'b0;
                if (start_ok) begin
                    d.st      = ST_XFER;
                    d.wr      = wr_i | ~rd_i;
                    d.half    = (cfg_width_i == WIDTH_CODE_16);
                    d.act_low = cfg_be_mode_i;
                    d.ha      = {addr_i[MEM_AW-1:0], 1'b0};
                    d.oe      = ~(wr_i | ~rd_i);
                end
            end
            ST_XFER: begin
                if (beat_ok) begin
                    d.ha = q.ha + (q.half ? HA'(1) : HA'(2));
                    if (blast_i) begin
                        d.st = ST_IDLE;
                        d.oe = 1'b0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, wr: 1'b0, half: 1'b0, act_low: 1'b0, oe: 1'b0, ha: '0};
        end else begin
            q <= d;
        end
    end

    // Checks beside the logic they guard.
    AST_OE_AFTER_READ_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && strobe_i && select_i && rd_i && !wr_i) |=> data_oe_o); // R3
    AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER && q.wr) |-> !data_oe_o); // R3
    AST_NO_STROBE_WITHOUT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(~rdy_in_n_i & rdy_in_i & ~rdy_out_n_i) |-> (mem_we_o == '0)); // R4
    AST_HOLD_ADDR_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER && !(~rdy_in_n_i & rdy_in_i & ~rdy_out_n_i)) |=> $stable(mem_addr_o)); // R4
    AST_OE_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER && beat_ok && blast_i) |=> !data_oe_o); // R5
    AST_WORD_STEP_32: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER && !q.half && beat_ok && !blast_i)
        |=> (mem_addr_o == $past(mem_addr_o) + MEM_AW'(1))); // R6
    AST_HALF_LANES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        q.half |-> ($countones(mem_we_o) <= HB)); // R8
    AST_LOW_READ_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q.half |-> (data_o[HW-1:0] == '0)); // R8
endmodule

// File: tb/lbus_slave_tb.sv
module lbus_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width_i = 2'b11;
    logic        cfg_be_mode_i = 1'b0;
    logic        strobe_i = 1'b0, select_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
    logic [12:0] addr_i = '0;
    logic [3:0]  be_i = '0;
    logic        blast_i = 1'b0;
    logic        rdy_in_n_i = 1'b1, rdy_in_i = 1'b0, rdy_out_n_i = 1'b1;
    logic [31:0] data_i = '0;
    logic [31:0] data_o, mem_wdata_o;
    logic        data_oe_o;
    logic [5:0]  mem_addr_o;
    logic [3:0]  mem_we_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_width_i(cfg_width_i), .cfg_be_mode_i(cfg_be_mode_i),
        .strobe_i(strobe_i), .select_i(select_i), .rd_i(rd_i), .wr_i(wr_i),
        .addr_i(addr_i), .be_i(be_i), .blast_i(blast_i), .rdy_in_n_i(rdy_in_n_i),
        .rdy_in_i(rdy_in_i), .rdy_out_n_i(rdy_out_n_i), .data_i(data_i), .data_o(data_o),
        .data_oe_o(data_oe_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o)
    );

    int  n_checks = 0, n_fail = 0;
    bit  done = 0;
    bit  is16 = 0, bmode = 0;
    logic [7:0]  bm [4*DEPTH];
    logic [31:0] q_exp [$];
    string       q_tag [$];
    bit          mon_req = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes(input logic [3:0] be);
        logic [3:0] en;
        en = bmode ? ~be : be;          // R7
        if (is16) en[1:0] = 2'b00;      // R8
        return en;
    endfunction

    function automatic int bidx(input int w, input int h, input int k);
        return is16 ? 4*w + 2*h + (k-2) : 4*w + k;
    endfunction

    function automatic logic [31:0] exp_read(input int w, input int h, input logic [3:0] be);
        logic [31:0] r;
        logic [3:0]  en;
        r = '0;
        en = lanes(be);
        for (int k = 0; k < 4; k++) if (en[k]) r[8*k +: 8] = bm[bidx(w, h, k)];
        return r;
    endfunction

    // Monitor: compare the read beat presented before each completing edge.
    always @(negedge clk) begin
        if (mon_req && q_exp.size() > 0) begin
            logic [31:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(data_o === e, t, data_o, e);
            check(data_oe_o === 1'b1, "R3", {31'b0, data_oe_o}, 32'd1);
        end
    end

    // special: 0 none, 1 ready stalls before beat 1, 2 start pulse before beat 1
    task automatic xfer(input int addr, input bit wr, input bit rd_too, input int n,
                        input logic [3:0] be, input logic [31:0] base, input int special,
                        input string tag);
        int w, h;
        w = addr % DEPTH;
        h = 0;
        strobe_i = 1; select_i = 1; wr_i = wr; rd_i = !wr | rd_too; addr_i = 13'(addr);
        @(negedge clk);
        check(data_oe_o === 1'b0, "R3", {31'b0, data_oe_o}, 32'd0);
        @(posedge clk); #1;
        strobe_i = 0; select_i = 0; wr_i = 0; rd_i = 0;
        for (int i = 0; i < n; i++) begin
            if (i == 1 && special == 1) begin
                data_i = 32'hDEAD_BEEF; be_i = bmode ? 4'h0 : 4'hF;
                rdy_in_n_i = 0; rdy_in_i = 0; rdy_out_n_i = 0;
                @(negedge clk);
                check(mem_we_o === 4'h0, "R4", {28'b0, mem_we_o}, 32'd0);
                @(posedge clk); #1;
                rdy_in_n_i = 0; rdy_in_i = 1; rdy_out_n_i = 1;
                @(negedge clk);
                check(mem_we_o === 4'h0, "R4", {28'b0, mem_we_o}, 32'd0);
                @(posedge clk); #1;
                rdy_in_n_i = 1; rdy_in_i = 1; rdy_out_n_i = 0;
                @(negedge clk);
                check(mem_we_o === 4'h0, "R4", {28'b0, mem_we_o}, 32'd0);
                @(posedge clk); #1;
            end
            if (i == 1 && special == 2) begin
                rdy_in_n_i = 1; rdy_in_i = 0; rdy_out_n_i = 1;
                strobe_i = 1; select_i = 1; wr_i = 1; addr_i = 13'd20;
                @(posedge clk); #1;
                strobe_i = 0; select_i = 0; wr_i = 0;
                @(negedge clk);
                check(data_oe_o === 1'b1, "R1", {31'b0, data_oe_o}, 32'd1);
                @(posedge clk); #1;
            end
            rdy_in_n_i = 0; rdy_in_i = 1; rdy_out_n_i = 0;
            be_i = be; blast_i = (i == n-1);
            data_i = base + 32'h0101_0101 * 32'(i);
            if (!wr) begin
                q_exp.push_back(exp_read(w, h, be));
                q_tag.push_back(tag);
                mon_req = 1;
            end else begin
                logic [3:0] en, ews;
                en = lanes(be);
                ews = is16 ? (h != 0 ? {en[3:2], 2'b00} : {2'b00, en[3:2]}) : en;
                @(negedge clk);
                check(mem_we_o === ews, is16 ? "R8" : "R9", {28'b0, mem_we_o}, {28'b0, ews});
                check(data_oe_o === 1'b0, "R3", {31'b0, data_oe_o}, 32'd0);
                for (int k = 0; k < 4; k++) if (en[k]) bm[bidx(w, h, k)] = data_i[8*k +: 8];
            end
            @(posedge clk); #1;
            mon_req = 0;
            rdy_in_n_i = 1; rdy_in_i = 0; rdy_out_n_i = 1; blast_i = 0;
            if (is16) begin
                if (h == 1) begin h = 0; w = (w + 1) % DEPTH; end else h = 1;
            end else w = (w + 1) % DEPTH;
        end
        @(negedge clk);
        check(data_oe_o === 1'b0, "R5", {31'b0, data_oe_o}, 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic bad_start(input bit s, input bit sel, input bit rd, input bit wr);
        strobe_i = s; select_i = sel; rd_i = rd; wr_i = wr; addr_i = 13'd3;
        @(posedge clk); #1;
        strobe_i = 0; select_i = 0; rd_i = 0; wr_i = 0;
        rdy_in_n_i = 0; rdy_in_i = 1; rdy_out_n_i = 0; be_i = 4'hF; blast_i = 1;
        data_i = 32'hFFFF_FFFF;
        @(negedge clk);
        check(data_oe_o === 1'b0, "R1", {31'b0, data_oe_o}, 32'd0);
        check(mem_we_o === 4'h0, "R1", {28'b0, mem_we_o}, 32'd0);
        @(posedge clk); #1;
        rdy_in_n_i = 1; rdy_in_i = 0; rdy_out_n_i = 1; blast_i = 0;
    endtask

    initial begin
        for (int i = 0; i < 4*DEPTH; i++) bm[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check(data_oe_o === 1'b0, "R11", {31'b0, data_oe_o}, 32'd0);
        check(mem_we_o === 4'h0, "R11", {28'b0, mem_we_o}, 32'd0);
        rst_n = 1;
        @(posedge clk); #1;

        // 32-bit, active-high enables
        is16 = 0; bmode = 0; cfg_width_i = 2'b11; cfg_be_mode_i = 0;
        xfer(37, 0, 0, 1, 4'hF, 0, 0, "R11");                  // cleared array
        xfer(5, 1, 0, 4, 4'hF, 32'h1020_3040, 1, "R4");        // stalled write burst
        xfer(5, 0, 0, 4, 4'hF, 0, 0, "R6");                    // word-stepping readback
        xfer(5 + 64, 0, 0, 1, 4'hF, 0, 0, "R10");              // upper address lines above array
        xfer(5, 0, 0, 1, 4'b0011, 0, 0, "R9");                 // disabled lanes read zero

        // active-low enables: be=1010 enables lanes 0 and 2
        bmode = 1; cfg_be_mode_i = 1;
        xfer(6, 1, 0, 1, 4'b1010, 32'hAABB_CCDD, 0, "R7");
        xfer(6, 0, 0, 1, 4'b0000, 0, 0, "R7");

        // rd and wr both high counts as write
        xfer(8, 1, 1, 1, 4'b0000, 32'h5566_7788, 0, "R2");
        xfer(8, 0, 0, 1, 4'b0000, 0, 0, "R2");

        // 16-bit mode, active-low, upper lanes only
        is16 = 1; cfg_width_i = 2'b01;
        xfer(10, 1, 0, 3, 4'b0000, 32'h1122_3344, 0, "R8");
        xfer(10, 0, 0, 3, 4'b0000, 0, 0, "R6");
        xfer(10, 0, 0, 1, 4'b0111, 0, 0, "R8");                // only lane 3
        is16 = 0; cfg_width_i = 2'b11;
        xfer(10, 0, 0, 2, 4'b0000, 0, 0, "R8");                // placement seen in 32-bit

        // qualification and ignored starts
        bad_start(1, 0, 1, 0);
        bad_start(0, 1, 1, 0);
        bad_start(1, 1, 0, 0);
        xfer(5, 0, 0, 2, 4'b0000, 0, 2, "R1");                 // start pulse mid-burst
        xfer(20, 0, 0, 1, 4'b0000, 0, 0, "R1");                // word 20 untouched

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule